// File: doc/BRIEF.md
# Planar Write Data Expansion Unit

This block sits between the CPU write port of a planar graphics controller and its four 8-bit memory planes. For every CPU byte written, it produces one data byte per plane and a single 8-bit bit-enable mask. The memory side uses these to update the addressed byte in all planes at once.

The CPU byte is first rotated right by a 3-bit amount. A 2-bit mode field then picks how the plane data is formed:

- The rotated byte is copied to every plane.
- A monochrome source is expanded into colour, with one colour bit steering each plane.
- Each plane takes a preloaded per-plane latch byte.

The expansion source is either the rotated CPU byte or a pattern register. An optional masked-write feature limits the update to selected bits. The mask comes from a mask register or from the rotated CPU byte.

Results are registered. They appear, with a one-cycle valid pulse, on the clock after the write strobe, and they hold until the next strobe.

Top module: `plane_write_expander`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `plane_data` is all zeros and `wr_mask` is 8'h00.
- R2: A write strobe sampled high at a clock edge gives `out_valid`=1 for exactly the following cycle. With no strobe, `out_valid` stays 0 and `plane_data`/`wr_mask` keep their last values, whatever the other inputs do.
- R3: With `mode`=0, every plane receives the CPU byte rotated right by `rot_amt` (0..7). Bit i of the result is bit (i+rot_amt) mod 8 of the CPU byte.
- R4: `mode`=3 produces exactly the same outputs as `mode`=0.
- R5: With `mode`=1, bit i of plane n is `fg_color[n]` where the expansion source bit i is 1, and `bg_color[n]` where it is 0.
- R6: In `mode`=1, `src_cpu`=1 takes the rotated CPU byte as the expansion source. `src_cpu`=0 takes `pattern`, and the CPU byte is then ignored.
- R7: With `mode`=2, plane n receives `fg_latch[8n+7:8n]`, independent of the CPU byte, `src_cpu` and `pattern`.
- R8: With `mask_en`=0, `wr_mask` is 8'hFF.
- R9: With `mask_en`=1 and `mask_src_cpu`=0, `wr_mask` equals `mask_reg`.
- R10: With `mask_en`=1 and `mask_src_cpu`=1, `wr_mask` equals the rotated CPU byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | CPU write strobe; captures a new result |
| cpu_byte | input | 8 | CPU write data |
| rot_amt | input | 3 | Right-rotate amount applied to the CPU byte |
| mode | input | 2 | 0 pass, 1 colour expansion, 2 latch dither, 3 as pass |
| src_cpu | input | 1 | Expansion source: 1 rotated CPU byte, 0 pattern |
| fg_color | input | 4 | Foreground colour, bit n for plane n |
| bg_color | input | 4 | Background colour, bit n for plane n |
| pattern | input | 8 | Pattern register used as expansion source |
| fg_latch | input | 32 | Per-plane latch bytes, plane n at bits 8n+7:8n |
| mask_en | input | 1 | Enables masked writes |
| mask_src_cpu | input | 1 | Mask source: 1 rotated CPU byte, 0 mask register |
| mask_reg | input | 8 | Write mask register |
| plane_data | output | 32 | Registered plane data, plane n at bits 8n+7:8n |
| wr_mask | output | 8 | Registered bit write-enable mask |
| out_valid | output | 1 | One-cycle pulse after a captured strobe |

## Verification
Pass mode is driven with rotate amounts 0, 1, 3 and 4 on asymmetric bytes such as 8'h81 and 8'h0F. A wrong rotation direction, or a shift used in place of a rotate, would give a different byte. Colour expansion is driven with foreground/background pairs that cover all four bit combinations across the planes, so a swapped colour or a swapped plane index shows up in a different plane. Pattern and CPU sources are given contrasting values so that the unused one cannot leak through. Dither and the three mask choices are each paired with data that differs from the values the other choices would select. Writes without a strobe, and a reset taken mid-run, check the holding and clearing of the output stage.

// File: rtl/pwx_pkg.sv
// Package: shared encodings for the planar write data expansion unit.
// Assumes the mode field is two bits wide and encoded as below.
package pwx_pkg;
    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_EXPAND = 2'd1,
        MODE_DITHER = 2'd2,
        MODE_RSVD   = 2'd3
    } wr_mode_e;
endpackage

// File: rtl/pwx_rotator.sv
// Module: right-rotates a data word by a variable amount.
// Assumes WIDTH is a power of two, so that the amount field covers every
// rotation exactly once.
module pwx_rotator #(
    parameter int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);
    // Purpose: output bit i takes input bit (i + amt) mod WIDTH.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            dout[i] = din[(i + int'(amt)) % WIDTH];
        end
    end
endmodule

// File: rtl/pwx_plane_gen.sv
// Module: forms the data byte of each plane from the selected write mode.
// Assumes the colour words carry one bit per plane and the latch word is
// packed with plane n in slice n.
module pwx_plane_gen
    import pwx_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int PIX_W  = 8,
    localparam int DATA_W = PLANES * PIX_W
) (
    input  wr_mode_e           mode,
    input  logic               src_cpu,
    input  logic [PIX_W-1:0]   rot_byte,
    input  logic [PIX_W-1:0]   pattern,
    input  logic [PLANES-1:0]  fg_color,
    input  logic [PLANES-1:0]  bg_color,
    input  logic [DATA_W-1:0]  fg_latch,
    output logic [DATA_W-1:0]  plane_data
);
    logic [PIX_W-1:0] exp_src;

    // Purpose: choose the monochrome bitmap that colour expansion consumes.
    always_comb begin
        exp_src = src_cpu ? rot_byte : pattern;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [PIX_W-1:0] expanded;

        // Purpose: per-pixel choice between this plane's fg and bg colour bit.
        always_comb begin
            for (int b = 0; b < PIX_W; b++) begin
                expanded[b] = exp_src[b] ? fg_color[p] : bg_color[p];
            end
        end

        // Purpose: pick this plane's output byte by write mode.
        always_comb begin
            unique case (mode)
                MODE_EXPAND: plane_data[p*PIX_W +: PIX_W] = expanded;
                MODE_DITHER: plane_data[p*PIX_W +: PIX_W] = fg_latch[p*PIX_W +: PIX_W];
                default:     plane_data[p*PIX_W +: PIX_W] = rot_byte;
            endcase
        end
    end
endmodule

// File: rtl/pwx_mask_sel.sv
// Module: derives the bit write-enable mask for one write.
// Assumes an all-ones mask means every bit is written.
module pwx_mask_sel #(
    parameter int PIX_W = 8
) (
    input  logic             mask_en,
    input  logic             mask_src_cpu,
    input  logic [PIX_W-1:0] mask_reg,
    input  logic [PIX_W-1:0] rot_byte,
    output logic [PIX_W-1:0] mask
);
    // Purpose: all-ones when masking is off, else register or rotated byte.
    always_comb begin
        if (!mask_en)          mask = '1;
        else if (mask_src_cpu) mask = rot_byte;
        else                   mask = mask_reg;
    end
endmodule

// File: rtl/plane_write_expander.sv
// Module: top of the planar write data expansion unit. It rotates the
// CPU byte, builds per-plane data and the write mask, and registers all
// of them on a write strobe.
// Assumes control inputs are stable in the cycle the strobe is sampled.
// Results appear one clock later and hold until the next strobe.
module plane_write_expander
    import pwx_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int PIX_W  = 8,
    localparam int DATA_W = PLANES * PIX_W,
    localparam int AMT_W  = $clog2(PIX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PIX_W-1:0]  cpu_byte,
    input  logic [AMT_W-1:0]  rot_amt,
    input  logic [1:0]        mode,
    input  logic              src_cpu,
    input  logic [PLANES-1:0] fg_color,
    input  logic [PLANES-1:0] bg_color,
    input  logic [PIX_W-1:0]  pattern,
    input  logic [DATA_W-1:0] fg_latch,
    input  logic              mask_en,
    input  logic              mask_src_cpu,
    input  logic [PIX_W-1:0]  mask_reg,
    output logic [DATA_W-1:0] plane_data,
    output logic [PIX_W-1:0]  wr_mask,
    output logic              out_valid
);
    logic [PIX_W-1:0]  rot_byte;
    logic [DATA_W-1:0] data_next;
    logic [PIX_W-1:0]  mask_next;

    pwx_rotator #(.WIDTH(PIX_W)) u_rot (
        .din  (cpu_byte),
        .amt  (rot_amt),
        .dout (rot_byte)
    );

    pwx_plane_gen #(.PLANES(PLANES), .PIX_W(PIX_W)) u_gen (
        .mode       (wr_mode_e'(mode)),
        .src_cpu    (src_cpu),
        .rot_byte   (rot_byte),
        .pattern    (pattern),
        .fg_color   (fg_color),
        .bg_color   (bg_color),
        .fg_latch   (fg_latch),
        .plane_data (data_next)
    );

    pwx_mask_sel #(.PIX_W(PIX_W)) u_mask (
        .mask_en      (mask_en),
        .mask_src_cpu (mask_src_cpu),
        .mask_reg     (mask_reg),
        .rot_byte     (rot_byte),
        .mask         (mask_next)
    );

    // Purpose: capture results on a strobe and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_data <= '0;
            wr_mask    <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= wr_stb;
            if (wr_stb) begin
                plane_data <= data_next;
                wr_mask    <= mask_next;
            end
        end
    end
endmodule

// File: rtl/pwx_checker.sv
// Module: property checker for plane_write_expander, attached by bind.
// Assumes the same parameters as the bound instance.
module pwx_checker #(
    parameter int PLANES = 4,
    parameter int PIX_W  = 8,
    localparam int DATA_W = PLANES * PIX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] fg_latch,
    input logic              mask_en,
    input logic              mask_src_cpu,
    input logic [PIX_W-1:0]  mask_reg,
    input logic [DATA_W-1:0] plane_data,
    input logic [PIX_W-1:0]  wr_mask,
    input logic              out_valid
);
    assert_valid_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> out_valid);

    assert_no_valid_without_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> !out_valid);

    assert_hold_without_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(plane_data) && $stable(wr_mask)));

    assert_dither_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode == 2'd2) |=> (plane_data == $past(fg_latch)));

    assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !mask_en) |=> (wr_mask == {PIX_W{1'b1}}));

    assert_mask_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mask_en && !mask_src_cpu) |=> (wr_mask == $past(mask_reg)));
endmodule

bind plane_write_expander pwx_checker #(.PLANES(PLANES), .PIX_W(PIX_W)) u_pwx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_stb       (wr_stb),
    .mode         (mode),
    .fg_latch     (fg_latch),
    .mask_en      (mask_en),
    .mask_src_cpu (mask_src_cpu),
    .mask_reg     (mask_reg),
    .plane_data   (plane_data),
    .wr_mask      (wr_mask),
    .out_valid    (out_valid)
);

// File: tb/plane_write_expander_bench.sv
`timescale 1ns/1ps
module plane_write_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  cpu_byte = '0;
    logic [2:0]  rot_amt = '0;
    logic [1:0]  mode = '0;
    logic        src_cpu = 1'b0;
    logic [3:0]  fg_color = '0;
    logic [3:0]  bg_color = '0;
    logic [7:0]  pattern = '0;
    logic [31:0] fg_latch = 32'h44332211;
    logic        mask_en = 1'b0;
    logic        mask_src_cpu = 1'b0;
    logic [7:0]  mask_reg = '0;
    logic [31:0] plane_data;
    logic [7:0]  wr_mask;
    logic        out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    plane_write_expander u_plane_write_expander (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cpu_byte(cpu_byte),
        .rot_amt(rot_amt), .mode(mode), .src_cpu(src_cpu),
        .fg_color(fg_color), .bg_color(bg_color), .pattern(pattern),
        .fg_latch(fg_latch), .mask_en(mask_en), .mask_src_cpu(mask_src_cpu),
        .mask_reg(mask_reg), .plane_data(plane_data), .wr_mask(wr_mask),
        .out_valid(out_valid)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        src;
        logic [7:0]  cpu;
        logic [2:0]  rot;
        logic [3:0]  fg;
        logic [3:0]  bg;
        logic [7:0]  pat;
        logic        men;
        logic        msrc;
        logic [7:0]  mreg;
        logic [31:0] exp_data;
        logic [7:0]  exp_mask;
    } vec_t;

    localparam int NVEC = 10;
    // Latch word is fixed at 32'h44332211 for every row.
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 8'hA5, 3'd0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 8'h00, 32'hA5A5A5A5, 8'hFF},
        '{2'd0, 1'b0, 8'h81, 3'd1, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 8'h00, 32'hC0C0C0C0, 8'hFF},
        '{2'd0, 1'b0, 8'h0F, 3'd4, 4'h0, 4'h0, 8'h00, 1'b1, 1'b1, 8'h00, 32'hF0F0F0F0, 8'hF0},
        '{2'd3, 1'b0, 8'h12, 3'd0, 4'h0, 4'h0, 8'h00, 1'b1, 1'b0, 8'h3C, 32'h12121212, 8'h3C},
        '{2'd1, 1'b1, 8'hF0, 3'd0, 4'h5, 4'h3, 8'h00, 1'b0, 1'b0, 8'h00, 32'h00F00FFF, 8'hFF},
        '{2'd1, 1'b0, 8'hFF, 3'd0, 4'hF, 4'h0, 8'hAA, 1'b0, 1'b0, 8'h00, 32'hAAAAAAAA, 8'hFF},
        '{2'd1, 1'b1, 8'h01, 3'd1, 4'h8, 4'h1, 8'h00, 1'b0, 1'b0, 8'h00, 32'h8000007F, 8'hFF},
        '{2'd2, 1'b1, 8'h77, 3'd0, 4'h0, 4'h0, 8'h00, 1'b1, 1'b1, 8'h00, 32'h44332211, 8'h77},
        '{2'd2, 1'b0, 8'h00, 3'd0, 4'hF, 4'hF, 8'h00, 1'b0, 1'b0, 8'h00, 32'h44332211, 8'hFF},
        '{2'd1, 1'b0, 8'h55, 3'd3, 4'h2, 4'h4, 8'h0F, 1'b1, 1'b1, 8'h00, 32'h00F00F00, 8'hAA}
    };

    function automatic string row_req(int i);
        case (i)
            0: return "R3/R8";
            1: return "R3";
            2: return "R3/R10";
            3: return "R4/R9";
            4: return "R5";
            5: return "R6";
            6: return "R5/R6";
            7: return "R7/R10";
            8: return "R7";
            default: return "R6/R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        mode = v.mode; src_cpu = v.src; cpu_byte = v.cpu; rot_amt = v.rot;
        fg_color = v.fg; bg_color = v.bg; pattern = v.pat;
        mask_en = v.men; mask_src_cpu = v.msrc; mask_reg = v.mreg;
    endtask

    // One strobed write; samples at the negedge after the capturing edge.
    task automatic do_write(vec_t v);
        @(negedge clk);
        apply(v);
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 data", plane_data, 32'd0);
        check("R1 mask", {24'd0, wr_mask}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i]);
            check({row_req(i), " data"}, plane_data, VECS[i].exp_data);
            check({row_req(i), " mask"}, {24'd0, wr_mask}, {24'd0, VECS[i].exp_mask});
            check("R2 valid pulse", {31'd0, out_valid}, 32'd1);
        end

        // R2: valid drops after one cycle; outputs hold while inputs change
        @(negedge clk);
        check("R2 valid low", {31'd0, out_valid}, 32'd0);
        apply(VECS[0]);
        fg_latch = 32'hDEADBEEF;
        repeat (2) @(negedge clk);
        check("R2 hold data", plane_data, 32'h00F00F00);
        check("R2 hold mask", {24'd0, wr_mask}, 32'h000000AA);
        check("R2 hold valid", {31'd0, out_valid}, 32'd0);

        // R7: new latch contents reach the planes
        do_write('{2'd2, 1'b0, 8'h00, 3'd0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, 8'h00, 32'h0, 8'h0});
        check("R7 new latch", plane_data, 32'hDEADBEEF);

        // R3: full rotation sweep in pass mode, expected computed by index rule
        for (int r = 0; r < 8; r++) begin
            logic [7:0] e;
            for (int b = 0; b < 8; b++) e[b] = 8'hB4 >> ((b + r) % 8);
            do_write('{2'd0, 1'b0, 8'hB4, r[2:0], 4'h0, 4'h0, 8'h00, 1'b1, 1'b1, 8'h00, 32'h0, 8'h0});
            check("R3 rot sweep", plane_data, {4{e}});
            check("R10 rot sweep mask", {24'd0, wr_mask}, {24'd0, e});
        end

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset data", plane_data, 32'd0);
        check("R1 mid reset mask", {24'd0, wr_mask}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule